// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block holds a 128-bit one-time-programmable fuse array and serves two commands on a single-cycle command port. A read returns one aligned 32-bit word of the array. A burn clears one user fuse from 1 to 0 after a programmable busy interval. No command can turn a 0 back into a 1.

The low 88 fuses belong to the user. Fuses 0 to 7 form a lock byte: a zero in lock bit k (k = 0..5) write-protects fuses 16k to 16k+15. Lock bit 0 sits inside the word it protects, so burning it also freezes the whole lock byte. Lock bits 6 and 7 guard no burnable fuse. Fuses 88 to 95 hold a manufacturer byte and fuses 96 to 127 hold a serial field. Both are loaded from parameters at reset and can never be burned.

A burn that passes its checks holds `busy` for a cycle count picked by a time code, then applies the change and returns status 0x00. A burn that fails any check returns 0x0F one cycle after it is accepted and leaves the array alone.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are 0, fuses 0..87 read as 1, fuses 88..95 equal `MFR_BYTE` and fuses 96..127 equal `SERIAL_BITS`.
- R2: A read (`cmd_op`=0) is answered in the cycle after acceptance, with `rsp_valid`=1, status 0x00 and `rsp_data` = fuses [32w+31:32w]. Here w = `cmd_arg[1:0]`, and fuse 32w sits on data bit 0. All other bits of `cmd_arg` are ignored.
- R3: An accepted burn (`cmd_op`=1, fuse number `cmd_arg`) that passes its checks clears exactly that fuse to 0 and returns status 0x00.
- R4: A passing burn holds `busy` high for exactly `SHORT_CYCLES` cycles when `cmd_time`=0x0000, or `LONG_CYCLES` cycles when `cmd_time`=0x8000. The response comes in the cycle after `busy` falls.
- R5: Any other `cmd_time` value rejects the burn with status 0x0F.
- R6: A burn to fuse number 88 or above (all 16 bits compared) is rejected with 0x0F. Fuses 88..127 never change.
- R7: If lock bit k (k = 0..5) is 0, a burn to fuses 16k..16k+15 is rejected with 0x0F. Burned lock bits 6 and 7 block nothing.
- R8: Once lock bit 0 is burned, no lock bit 0..7 can change, while words 1..5 follow their own lock bits.
- R9: A burn to a fuse that already reads 0 is rejected with 0x0F.
- R10: A rejected burn answers one cycle after acceptance without raising `busy`, and it leaves the array unchanged.
- R11: Commands presented while `busy` is high are ignored. They produce no response and change no fuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, accepted when `busy` is low |
| cmd_op | input | 1 | 0 = read word, 1 = burn fuse |
| cmd_arg | input | 16 | Read: word select in bits 1:0. Burn: fuse number |
| cmd_time | input | 16 | Burn duration code, 0x0000 short or 0x8000 long |
| busy | output | 1 | High while a burn is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 8 | 0x00 success, 0x0F execution error |
| rsp_data | output | 32 | Read word, zero for burns |

## Verification
The bench targets the lock rules. It burns a mid-array lock bit and then probes fuses inside and outside the guarded word. Without the check, a protected fuse would be cleared. With an off-by-one word decode, a neighbouring word would be blocked instead. It burns lock bit 0 and then tries another lock bit, which only a design that treats the lock byte as ordinary data would accept. It also drives fuse numbers 88, 127 and 300, reburns a cleared fuse, and sends burn time codes that are neither 0x0000 nor 0x8000. A design that masks the fuse number or decodes a single time bit would then corrupt the identity words or start a burn. Busy length is counted cycle by cycle for both durations. A burn and a read are injected while busy is high, to catch a design that lets them through.

// File: rtl/otp_pkg.sv
// Shared opcodes and status codes for the fuse array controller.
// Assumes an 8-bit status byte and a single-bit opcode.
package otp_pkg;
    typedef enum logic {OP_READ = 1'b0, OP_BURN = 1'b1} otp_op_e;
    localparam logic [7:0] ST_OK  = 8'h00;
    localparam logic [7:0] ST_ERR = 8'h0F;
    localparam logic [15:0] TCODE_SHORT = 16'h0000;
    localparam logic [15:0] TCODE_LONG  = 16'h8000;
endpackage

// File: rtl/otp_fuse_store.sv
// Fuse storage: user bits reset to 1 and can only be cleared. The
// identity bits above USER_BITS reset to parameter values and then hold.
// Assumes clr_en is raised only for a user-range index.
module otp_fuse_store #(
    parameter int FUSES     = 128,
    parameter int USER_BITS = 88,
    parameter logic [FUSES-USER_BITS-1:0] IDENT = '0,
    localparam int IDX_W    = $clog2(FUSES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [FUSES-1:0] fuses
);
    for (genvar i = 0; i < FUSES; i++) begin : g_bit
        if (i < USER_BITS) begin : g_user
            // user fuse: set at reset, one-way clear afterwards
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fuses[i] <= 1'b1;
                else if (clr_en && (clr_idx == IDX_W'(i)))
                    fuses[i] <= 1'b0;
            end
        end else begin : g_ident
            // identity fuse: loaded at reset, never written
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fuses[i] <= IDENT[i-USER_BITS];
            end
        end
    end
endmodule

// File: rtl/otp_burn_check.sv
// Combinational validation of a burn request: range, time code, word
// lock and already-burned state. Assumes lock bits sit at fuses 0..LOCK_BITS-1.
module otp_burn_check #(
    parameter int FUSES     = 128,
    parameter int USER_BITS = 88,
    parameter int LOCK_SPAN = 16,
    localparam int IDX_W    = $clog2(FUSES),
    localparam int LOCK_EFF = (USER_BITS + LOCK_SPAN - 1) / LOCK_SPAN
) (
    input  logic [FUSES-1:0] fuses,
    input  logic [15:0]      fuse_num,
    input  logic [15:0]      time_code,
    output logic             ok,
    output logic             long_sel,
    output logic [IDX_W-1:0] idx
);
    import otp_pkg::*;
    logic in_range, time_ok, locked, already;
    logic [LOCK_EFF-1:0] word_hit;

    // one lock decode per protected word
    for (genvar k = 0; k < LOCK_EFF; k++) begin : g_lock
        assign word_hit[k] = (int'(idx) / LOCK_SPAN == k) && !fuses[k];
    end

    // combine all rejection causes
    always_comb begin
        idx      = fuse_num[IDX_W-1:0];
        in_range = fuse_num < 16'(USER_BITS);
        long_sel = (time_code == TCODE_LONG);
        time_ok  = (time_code == TCODE_SHORT) || long_sel;
        locked   = |word_hit;
        already  = !fuses[idx];
        ok       = in_range && time_ok && !locked && !already;
    end
endmodule

// File: rtl/otp_burn_timer.sv
// Down-counter that holds busy for the selected cycle count and pulses done
// on the last busy cycle. Assumes both counts are at least 1.
module otp_burn_timer #(
    parameter int SHORT_CYCLES = 12,
    parameter int LONG_CYCLES  = 40,
    localparam int CNT_W = $clog2(LONG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_sel,
    output logic busy,
    output logic done
);
    logic [CNT_W-1:0] remain;

    assign done = busy && (remain == '0);

    // load, count down, release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            remain <= long_sel ? CNT_W'(LONG_CYCLES - 1) : CNT_W'(SHORT_CYCLES - 1);
        end else if (done) begin
            busy   <= 1'b0;
        end else if (busy) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/otp_fuse_ctrl.sv
// Fuse array controller top: accepts read and burn commands when idle,
// answers reads and rejected burns in one cycle, and passing burns after
// the busy interval. Assumes cmd_* are held valid only in the accept cycle.
module otp_fuse_ctrl #(
    parameter int FUSES        = 128,
    parameter int USER_BITS    = 88,
    parameter int LOCK_SPAN    = 16,
    parameter int WORD_W       = 32,
    parameter int SHORT_CYCLES = 12,
    parameter int LONG_CYCLES  = 40,
    parameter logic [7:0]  MFR_BYTE    = 8'h77,
    parameter logic [31:0] SERIAL_BITS = 32'h8899AABB,
    localparam int IDX_W   = $clog2(FUSES),
    localparam int WSEL_W  = $clog2(FUSES / WORD_W)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_op,
    input  logic [15:0] cmd_arg,
    input  logic [15:0] cmd_time,
    output logic        busy,
    output logic        rsp_valid,
    output logic [7:0]  rsp_status,
    output logic [31:0] rsp_data
);
    import otp_pkg::*;

    logic [FUSES-1:0] fuse_q;
    logic             accept, is_burn, chk_ok, chk_long, tmr_done;
    logic [IDX_W-1:0] chk_idx, pend_idx;
    logic [WSEL_W-1:0] wsel;

    assign accept  = cmd_valid && !busy;
    assign is_burn = (otp_op_e'(cmd_op) == OP_BURN);
    assign wsel    = cmd_arg[WSEL_W-1:0];

    otp_fuse_store #(
        .FUSES(FUSES), .USER_BITS(USER_BITS), .IDENT({SERIAL_BITS, MFR_BYTE})
    ) u_store (
        .clk(clk), .rst_n(rst_n), .clr_en(tmr_done), .clr_idx(pend_idx), .fuses(fuse_q)
    );

    otp_burn_check #(
        .FUSES(FUSES), .USER_BITS(USER_BITS), .LOCK_SPAN(LOCK_SPAN)
    ) u_check (
        .fuses(fuse_q), .fuse_num(cmd_arg), .time_code(cmd_time),
        .ok(chk_ok), .long_sel(chk_long), .idx(chk_idx)
    );

    otp_burn_timer #(
        .SHORT_CYCLES(SHORT_CYCLES), .LONG_CYCLES(LONG_CYCLES)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .start(accept && is_burn && chk_ok),
        .long_sel(chk_long), .busy(busy), .done(tmr_done)
    );

    // remember which fuse the running burn will clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_idx <= '0;
        else if (accept && is_burn && chk_ok)
            pend_idx <= chk_idx;
    end

    // response register: reads, immediate errors and burn completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= ST_OK;
            rsp_data   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (tmr_done) begin
                rsp_valid  <= 1'b1;
                rsp_status <= ST_OK;
                rsp_data   <= '0;
            end else if (accept && !is_burn) begin
                rsp_valid  <= 1'b1;
                rsp_status <= ST_OK;
                rsp_data   <= fuse_q[wsel*WORD_W +: WORD_W];
            end else if (accept && !chk_ok) begin
                rsp_valid  <= 1'b1;
                rsp_status <= ST_ERR;
                rsp_data   <= '0;
            end
        end
    end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
// Assertion checker for otp_fuse_ctrl, attached with bind.
module otp_fuse_ctrl_chk #(
    parameter int FUSES     = 128,
    parameter int USER_BITS = 88,
    parameter int LONG_CYCLES = 40,
    parameter logic [FUSES-USER_BITS-1:0] IDENT = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             rsp_valid,
    input logic [7:0]       rsp_status,
    input logic [FUSES-1:0] fuse_q
);
    int busy_run;

    // length of the current busy stretch
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_run <= 0;
        else                 busy_run <= busy_run + 1;
    end

    a_r3_never_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fuse_q & ~$past(fuse_q)) == '0));
    a_r6_ident_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_q[FUSES-1:USER_BITS] == IDENT);
    a_r8_lock_byte_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !fuse_q[0] |=> $stable(fuse_q[7:0]));
    a_r4_done_ok: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (rsp_valid && rsp_status == 8'h00));
    a_r11_no_rsp_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rsp_valid);
    a_r4_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= LONG_CYCLES);
    a_r10_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status == 8'h00 || rsp_status == 8'h0F));
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(
    .FUSES(FUSES), .USER_BITS(USER_BITS), .LONG_CYCLES(LONG_CYCLES),
    .IDENT({SERIAL_BITS, MFR_BYTE})
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .fuse_q(fuse_q)
);

// File: tb/otp_fuse_ctrl_tb.sv
// Directed bench for otp_fuse_ctrl: one task per scenario, each checking itself.
module otp_fuse_ctrl_tb;
    localparam int SHORT = 12;
    localparam int LONG  = 40;
    localparam logic [7:0]  MFR = 8'h77;
    localparam logic [31:0] SER = 32'h8899AABB;

    logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, cmd_op = 1'b0;
    logic [15:0] cmd_arg = '0, cmd_time = '0;
    logic busy, rsp_valid;
    logic [7:0] rsp_status;
    logic [31:0] rsp_data;

    int checks = 0, errors = 0, cyc = 0;
    logic [127:0] model;

    always #10 clk = ~clk;

    otp_fuse_ctrl #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG),
                    .MFR_BYTE(MFR), .SERIAL_BITS(SER)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_time(cmd_time), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic op, input logic [15:0] arg, input logic [15:0] tc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg; cmd_time = tc;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [15:0] arg);
        logic [1:0] w;
        w = arg[1:0];
        pulse(1'b0, arg, 16'h0);
        check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check({req, " read status"}, 32'(rsp_status), 32'h00);
        check({req, " read data"}, rsp_data, model[w*32 +: 32]);
    endtask

    // expected outcome computed from the requirements
    function automatic bit burn_passes(input logic [15:0] n, input logic [15:0] tc);
        if (!(tc == 16'h0000 || tc == 16'h8000)) return 0;
        if (n >= 16'd88) return 0;
        if (n / 16 < 6 && !model[n / 16]) return 0;
        if (!model[n[6:0]]) return 0;
        return 1;
    endfunction

    task automatic do_burn(input string req, input logic [15:0] n, input logic [15:0] tc);
        bit pass;
        int b;
        pass = burn_passes(n, tc);
        pulse(1'b1, n, tc);
        b = 0;
        while (busy && b < 1000) begin b++; @(negedge clk); end
        check({req, " busy cycles"}, 32'(b), pass ? (tc == 16'h8000 ? LONG : SHORT) : 0);
        check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check({req, " burn status"}, 32'(rsp_status), pass ? 32'h00 : 32'h0F);
        if (pass) model[n[6:0]] = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 busy", 32'(busy), 0);
        check("R1 rsp_valid", 32'(rsp_valid), 0);
        for (int w = 0; w < 4; w++) do_read("R1 R2 word", 16'(w));
    endtask

    task automatic t_read_alias;
        do_read("R2 upper addr ignored", 16'hFFF6);
        do_read("R2 upper addr ignored", 16'h8001);
    endtask

    task automatic t_burn_basic;
        do_burn("R3 R4 short", 16'd40, 16'h0000);
        do_read("R3 word1", 16'd1);
        do_burn("R4 long", 16'd9, 16'h8000);
        do_read("R3 word0", 16'd0);
    endtask

    task automatic t_bad_time;
        do_burn("R5 tc 0001", 16'd41, 16'h0001);
        do_burn("R5 tc 4000", 16'd41, 16'h4000);
        do_burn("R5 R10 tc 8001", 16'd41, 16'h8001);
        do_read("R10 word1 unchanged", 16'd1);
    endtask

    task automatic t_range;
        do_burn("R6 fuse 88", 16'd88, 16'h0000);
        do_burn("R6 fuse 127", 16'd127, 16'h0000);
        do_burn("R6 fuse 300", 16'd300, 16'h0000);
        do_burn("R6 fuse 0x8058", 16'h8058, 16'h0000);
        do_read("R6 word2", 16'd2);
        do_read("R6 word3", 16'd3);
    endtask

    task automatic t_reburn;
        do_burn("R9 reburn", 16'd40, 16'h0000);
    endtask

    task automatic t_lock;
        do_burn("R7 lock bit2", 16'd2, 16'h0000);
        do_burn("R7 locked word2", 16'd33, 16'h0000);
        do_burn("R7 open word3", 16'd50, 16'h0000);
        do_burn("R7 lock bit6", 16'd6, 16'h0000);
        do_burn("R7 lock bit7", 16'd7, 16'h0000);
        do_burn("R7 word4 after 6/7", 16'd70, 16'h0000);
        do_read("R7 word1", 16'd1);
        do_read("R7 word2", 16'd2);
    endtask

    task automatic t_busy_ignore;
        int rsp_cnt;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b1; cmd_arg = 16'd60; cmd_time = 16'h8000;
        @(negedge clk);
        cmd_arg = 16'd61; cmd_time = 16'h0000;
        rsp_cnt = 0;
        @(negedge clk);
        cmd_op = 1'b0; cmd_arg = 16'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy && cyc < 100000) begin
            if (rsp_valid) rsp_cnt++;
            @(negedge clk);
        end
        if (rsp_valid) rsp_cnt++;
        check("R11 single response", 32'(rsp_cnt), 32'd1);
        check("R11 status", 32'(rsp_status), 32'h00);
        model[60] = 1'b0;
        @(negedge clk);
        check("R11 no late rsp", 32'(rsp_valid), 32'd0);
        do_read("R11 fuse61 kept", 16'd1);
    endtask

    task automatic t_lock0;
        do_burn("R8 lock bit0", 16'd0, 16'h0000);
        do_burn("R8 lock bit3 frozen", 16'd3, 16'h0000);
        do_burn("R8 word1 still open", 16'd20, 16'h0000);
        do_read("R8 word0", 16'd0);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model = {SER, MFR, 88'hFFFFFF_FFFFFFFF_FFFFFFFF};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_read_alias;
        t_burn_basic;
        t_bad_time;
        t_range;
        t_reburn;
        t_lock;
        t_busy_ignore;
        t_lock0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule